// File: doc/BRIEF.md
# Four-Way Memory Bank Decoder

This block is the address decoder that sits between an 8-bit processor with a 64 KiB address space and its local memories. For every memory request it decides which memory answers: a boot ROM, one of three local RAM regions, or a video RAM. It also gives the address offset within the chosen region. The mapping depends on a two-bit bank number. That number is built from two control bits, which are held in registers inside the block.

The low control bit is the initial-load bit. It is the inverse of an active-low modem-control output of a serial controller, and it is sampled on every clock. The high control bit is the memory-select bit. It is loaded when the processor writes the bank-select register. Bank 0 runs from the boot ROM. Bank 1 replaces the ROM with RAM, so that loaded code can run. Bank 2 keeps the ROM and leaves the upper half of the address space unmapped. Bank 3 replaces the ROM with RAM and maps the video RAM into the upper half.

The decoder also gates the write enable so that writes to ROM or to unmapped space go nowhere. It drives an all-ones fill byte for reads from unmapped space.

Top module: `bank_decoder`

## Requirements
- R1: The bank number is the initial-load bit plus twice the memory-select bit. A change of either bit changes the decode starting from the first clock edge after the change is presented.
- R2: The initial-load bit is the logical inverse of `load_line_n`, sampled on each rising clock edge. The memory-select bit loads `msel_val` on a rising edge only when `msel_wr` is high, and otherwise holds its value.
- R3: In bank 0, addresses 0x0000–0x1FFF select the ROM (cs_o bit 0). Addresses 0x2000–0x7FFF select RAM region 1 (cs_o bit 2). Addresses 0x8000–0xFFFF select RAM region 2 (cs_o bit 3).
- R4: In bank 1, addresses 0x0000–0x1FFF select RAM region 0 (cs_o bit 1). Addresses 0x2000–0x7FFF select RAM region 1. Addresses 0x8000–0xFFFF select RAM region 2.
- R5: In bank 2, addresses 0x0000–0x1FFF select the ROM and addresses 0x2000–0x7FFF select RAM region 1. Addresses 0x8000–0xFFFF select nothing.
- R6: In bank 3, addresses 0x0000–0x1FFF select RAM region 0 and addresses 0x2000–0x7FFF select RAM region 1. Addresses 0x8000–0xFFFF select the video RAM (cs_o bit 4).
- R7: A synchronous reset clears both control bits, so that the decode is bank 0 whatever `load_line_n` and `msel_wr` are doing.
- R8: A read (mreq_i=1, wr_i=0) that selects nothing drives `fill_o` to 0xFF. In every other case `fill_o` is 0x00.
- R9: `wr_en_o` is high only for a write (mreq_i=1, wr_i=1) that selects a RAM region or the video RAM. Writes to ROM or to unmapped space leave it low.
- R10: `offset_o` is the address minus the base of the selected region. The bases are 0x0000 for ROM and RAM region 0, 0x2000 for RAM region 1, and 0x8000 for RAM region 2 and video RAM. When nothing is selected, `offset_o` is 0.
- R11: With `mreq_i` low, `cs_o` and `offset_o` are all zero and `wr_en_o` is low.
- R12: At most one bit of `cs_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_line_n | input | 1 | Active-low serial-controller output that drives the initial-load bit |
| msel_wr | input | 1 | Write strobe of the bank-select register |
| msel_val | input | 1 | Value for the memory-select bit |
| addr_i | input | 16 | Processor address |
| mreq_i | input | 1 | Memory request strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| cs_o | output | 5 | One-hot chip selects: ROM, RAM0, RAM1, RAM2, VRAM (bits 0 to 4) |
| offset_o | output | 16 | Offset within the selected region |
| wr_en_o | output | 1 | Qualified write enable for the selected memory |
| fill_o | output | 8 | Fill byte for reads from unmapped space |

## Verification
The hardest case to reach is the upper half of bank 2. Getting there needs the serial line held high and a register write that sets the memory-select bit, and both must be registered before the access is decoded. The stimulus sets both control bits through a dedicated task. That task waits out the register stage and then sweeps region boundaries with reads and writes in each of the four banks. It also drives a select value with the write strobe low, to show that the bank does not move. It holds the control inputs in their non-zero state during reset, to show that bank 0 wins.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;

    localparam int NUM_CS = 5;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_ROM,
        RG_RAM0,
        RG_RAM1,
        RG_RAM2,
        RG_VRAM
    } region_e;

    // Chip-select vector for a decoded region: bit 0 ROM .. bit 4 VRAM.
    function automatic logic [NUM_CS-1:0] region_to_cs(region_e r);
        logic [NUM_CS-1:0] cs;
        cs = '0;
        case (r)
            RG_ROM:  cs[0] = 1'b1;
            RG_RAM0: cs[1] = 1'b1;
            RG_RAM1: cs[2] = 1'b1;
            RG_RAM2: cs[3] = 1'b1;
            RG_VRAM: cs[4] = 1'b1;
            default: cs = '0;
        endcase
        return cs;
    endfunction

    function automatic logic region_writable(region_e r);
        return (r == RG_RAM0) || (r == RG_RAM1) || (r == RG_RAM2) || (r == RG_VRAM);
    endfunction

endpackage

// File: rtl/bank_ctl.sv
module bank_ctl (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_line_n,
    input  logic       msel_wr,
    input  logic       msel_val,
    output logic [1:0] bank
);
    logic il_q;
    logic msel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            il_q   <= 1'b0;
            msel_q <= 1'b0;
        end else begin
            il_q <= ~load_line_n;
            if (msel_wr)
                msel_q <= msel_val;
        end
    end

    // initial-load bit weighs 1, memory-select bit weighs 2
    assign bank = {msel_q, il_q};

    // R7
    reset_to_bank0_chk: assert property (@(posedge clk) rst |=> (bank == 2'd0));

    // R2
    msel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !msel_wr |=> $stable(bank[1]));

endmodule

// File: rtl/region_dec.sv
module region_dec
    import bank_dec_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int LOW_TOP = 'h2000,
    parameter int HI_BASE = 'h8000
) (
    input  logic [1:0]        bank,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mreq,
    output region_e           region,
    output logic [ADDR_W-1:0] offset
);
    localparam logic [ADDR_W-1:0] LOW_A = LOW_TOP[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] HI_A  = HI_BASE[ADDR_W-1:0];

    region_e           rg;
    logic [ADDR_W-1:0] base;

    always_comb begin
        rg   = RG_NONE;
        base = '0;
        if (addr < LOW_A) begin
            rg   = bank[0] ? RG_RAM0 : RG_ROM;
            base = '0;
        end else if (addr < HI_A) begin
            rg   = RG_RAM1;
            base = LOW_A;
        end else begin
            base = HI_A;
            case (bank)
                2'd2:    rg = RG_NONE;
                2'd3:    rg = RG_VRAM;
                default: rg = RG_RAM2;
            endcase
        end
        if (!mreq)
            rg = RG_NONE;
    end

    assign region = rg;
    assign offset = (rg == RG_NONE) ? '0 : addr - base;

endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
    import bank_dec_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int LOW_TOP = 'h2000,
    parameter int HI_BASE = 'h8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_line_n,
    input  logic              msel_wr,
    input  logic              msel_val,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              mreq_i,
    input  logic              wr_i,
    output logic [NUM_CS-1:0] cs_o,
    output logic [ADDR_W-1:0] offset_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] fill_o
);
    logic [1:0] bank;
    region_e    region;

    bank_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .load_line_n(load_line_n),
        .msel_wr    (msel_wr),
        .msel_val   (msel_val),
        .bank       (bank)
    );

    region_dec #(
        .ADDR_W (ADDR_W),
        .LOW_TOP(LOW_TOP),
        .HI_BASE(HI_BASE)
    ) u_dec (
        .bank  (bank),
        .addr  (addr_i),
        .mreq  (mreq_i),
        .region(region),
        .offset(offset_o)
    );

    assign cs_o    = region_to_cs(region);
    assign wr_en_o = mreq_i && wr_i && region_writable(region);
    assign fill_o  = (mreq_i && !wr_i && region == RG_NONE) ? {DATA_W{1'b1}} : '0;

    // R12
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(cs_o));

    // R9
    rom_write_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        cs_o[0] |-> !wr_en_o);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !mreq_i |-> (cs_o == '0 && !wr_en_o && offset_o == '0));

    // R8
    fill_only_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_o != '0) |-> (cs_o == '0 && !wr_en_o));

    // R9
    wr_en_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (cs_o != '0));

endmodule

// File: tb/bank_decoder_tb.sv
module bank_decoder_tb_top;

    typedef struct {
        logic [4:0]  cs;
        logic [15:0] off;
        logic        we;
        logic [7:0]  fill;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_line_n = 1'b1;
    logic        msel_wr = 1'b0;
    logic        msel_val = 1'b0;
    logic [15:0] addr_i = '0;
    logic        mreq_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [4:0]  cs_o;
    logic [15:0] offset_o;
    logic        wr_en_o;
    logic [7:0]  fill_o;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 0;
    exp_t exp_q[$];
    logic m_il = 1'b0;
    logic m_msel = 1'b0;

    always #5 clk = ~clk;

    bank_decoder dut_i (
        .clk(clk), .rst(rst), .load_line_n(load_line_n), .msel_wr(msel_wr),
        .msel_val(msel_val), .addr_i(addr_i), .mreq_i(mreq_i), .wr_i(wr_i),
        .cs_o(cs_o), .offset_o(offset_o), .wr_en_o(wr_en_o), .fill_o(fill_o)
    );

    // Reference map written from the requirements
    function automatic exp_t model(int bank, logic [15:0] a, logic mreq, logic wr, string tag);
        exp_t e;
        int   base = 0;
        e.cs = '0;
        e.tag = tag;
        if (a < 16'h2000) begin
            e.cs = (bank == 1 || bank == 3) ? 5'b00010 : 5'b00001;
            base = 0;
        end else if (a < 16'h8000) begin
            e.cs = 5'b00100;
            base = 'h2000;
        end else begin
            base = 'h8000;
            if (bank == 0 || bank == 1) e.cs = 5'b01000;
            else if (bank == 3)         e.cs = 5'b10000;
            else                        e.cs = 5'b00000;
        end
        if (!mreq) e.cs = '0;
        e.off  = (e.cs == 0) ? 16'h0 : 16'(int'(a) - base);
        e.we   = mreq && wr && (e.cs != 0) && (e.cs != 5'b00001);
        e.fill = (mreq && !wr && e.cs == 0) ? 8'hFF : 8'h00;
        return e;
    endfunction

    task automatic access(logic [15:0] a, logic mreq, logic wr, string tag);
        @(negedge clk);
        addr_i = a;
        mreq_i = mreq;
        wr_i   = wr;
        exp_q.push_back(model(int'(m_il) + 2 * int'(m_msel), a, mreq, wr, tag));
    endtask

    // R1 R2: present both control values, let one edge register them
    task automatic set_ctl(logic line_n, logic strobe, logic val);
        @(negedge clk);
        mreq_i      = 1'b0;
        load_line_n = line_n;
        msel_wr     = strobe;
        msel_val    = val;
        @(negedge clk);
        msel_wr = 1'b0;
        m_il = ~line_n;
        if (strobe) m_msel = val;
    endtask

    task automatic sweep(string tag);
        access(16'h0000, 1'b1, 1'b0, tag);
        access(16'h1FFF, 1'b1, 1'b1, tag);
        access(16'h1234, 1'b1, 1'b0, tag);
        access(16'h2000, 1'b1, 1'b1, tag);
        access(16'h7FFF, 1'b1, 1'b0, tag);
        access(16'h8000, 1'b1, 1'b0, tag);
        access(16'hFFFF, 1'b1, 1'b1, tag);
        access(16'hC0DE, 1'b1, 1'b0, tag);
        access(16'h9000, 1'b0, 1'b1, "R11 idle");
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (cs_o !== e.cs || offset_o !== e.off || wr_en_o !== e.we || fill_o !== e.fill) begin
                    n_fail++;
                    $display("FAIL %s addr=%h: cs=%b off=%h we=%b fill=%h, expected cs=%b off=%h we=%b fill=%h",
                             e.tag, addr_i, cs_o, offset_o, wr_en_o, fill_o, e.cs, e.off, e.we, e.fill);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R7: control inputs request bank 3 while reset is held
        load_line_n = 1'b0;
        msel_wr     = 1'b1;
        msel_val    = 1'b1;
        repeat (3) @(posedge clk);
        access(16'h0100, 1'b1, 1'b0, "R7 reset bank0 low");
        access(16'hA000, 1'b1, 1'b1, "R7 reset bank0 high");
        @(negedge clk);
        load_line_n = 1'b1;
        msel_wr     = 1'b0;
        msel_val    = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        sweep("R3 R10 bank0");
        set_ctl(1'b0, 1'b1, 1'b0);
        sweep("R4 R1 bank1");
        set_ctl(1'b1, 1'b1, 1'b1);
        sweep("R5 R8 bank2");
        set_ctl(1'b0, 1'b1, 1'b1);
        sweep("R6 R9 bank3");
        // R2: select value presented without strobe is ignored
        set_ctl(1'b0, 1'b0, 1'b0);
        access(16'hFFFE, 1'b1, 1'b1, "R2 no strobe keeps bank3");
        // R2: line alone drops initial-load bit, bank 3 -> 2
        set_ctl(1'b1, 1'b0, 1'b0);
        access(16'h8001, 1'b1, 1'b0, "R2 line high bank2");
        access(16'h0005, 1'b1, 1'b1, "R9 rom write bank2");
        set_ctl(1'b1, 1'b1, 1'b0);
        access(16'h4000, 1'b1, 1'b1, "R1 back to bank0");
        access(16'h8000, 1'b1, 1'b0, "R1 back to bank0 high");

        repeat (4) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule